// File: doc/BRIEF.md
# Ternary Rule Column Loader

This block loads ternary match rules into the bit-vector SRAM units of a partitioned ternary lookup table. The table is split across its key into N subwords of W bits and across its entries into L layers of K entries each. Every unit belongs to one layer and one subword position. It has 2^W rows that are addressed by a binary subword value. Each row holds K bits, one per entry of the layer. A rule sits in one column of each unit of its layer. In a given unit, that column is 1 in every row whose address is covered by the rule's ternary subword and 0 in every other row.

A command carries an entry address, a value word, a care mask (a mask bit of 1 marks that key bit as don't-care) and a delete flag. The upper address bits select the layer and the lower bits select the column. Once a command is accepted, the engine sweeps every row of every unit in that layer, unit by unit, and issues one single-column write per cycle. The write sets or clears the target column only, so the other entries in the same row are left alone. A delete command runs the same sweep with every written bit forced to 0. The engine refuses new commands while it sweeps and signals completion with a one-cycle pulse.

Top module: `ternary_rule_mapper`

## Requirements
- R1: After reset, busy, done and wrEn are low and cmdReady is high.
- R2: A command is taken only when cmdValid and cmdReady are both high at a clock edge. cmdReady is low for the whole sweep, and a cmdValid raised during a sweep has no effect on the writes or on what follows.
- R3: The write cycle right after acceptance targets wrUnit 0, wrRow 0. The row steps by one every cycle and the unit steps by one after row 2^W-1. There are exactly N*2^W write cycles, ending at unit N-1, row 2^W-1.
- R4: During a sweep, wrColSel is one-hot, with bit c set where c is the command address modulo K, and wrLayer equals the command address divided by K. Both hold steady for the whole sweep.
- R5: For an insert, wrBit is 1 exactly when, for every key bit j of the current subword (key bits [u*W +: W] for unit u) whose mask bit is 0, the row address bit j equals the value bit.
- R6: In one unit, an insert writes a 1 to exactly 2^d rows, where d is the number of mask bits set in that subword. An all-care subword therefore marks one row and an all-don't-care subword marks every row.
- R7: For a delete, wrBit is 0 on every write cycle of the sweep, which clears the entry's column in every unit of its layer.
- R8: done is high for exactly one cycle, the cycle after the last write. In that cycle busy is low and cmdReady is high.
- R9: wrEn is high exactly while busy is high and is low at all other times.
- R10: Loading a rule at an occupied address replaces the old rule. Rows covered only by the old rule end with a 0 in that column, and columns of other entries in the same rows are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Engine can take a command |
| cmdDelete | input | 1 | 1 = remove the entry, 0 = insert the rule |
| cmdAddr | input | log2(L*K) | Entry address: layer in the upper bits, column in the lower log2(K) bits |
| cmdValue | input | N*W | Rule value bits |
| cmdMask | input | N*W | Don't-care mask, 1 = ignore that key bit |
| wrEn | output | 1 | Single-column write strobe |
| wrLayer | output | log2(L) | Layer of the unit written |
| wrUnit | output | log2(N) | Subword unit written |
| wrRow | output | W | Row address written |
| wrColSel | output | K | One-hot column enable |
| wrBit | output | 1 | Value written into the selected column |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The checker watches the sweep's shape on every cycle: that it starts at unit 0 row 0, that the row and unit step correctly and stop at the end, that the one-hot column and the layer stay fixed, that done follows the fall of busy, and that wrEn tracks busy. Whether each written bit is correct for the rule's ternary pattern, how many rows each unit marks, and whether deletes and overwrites leave the right table contents can only be shown by the bench's scenarios. The bench applies the writes to its own copy of the units and compares that copy against rules it tracks independently. Refusal of a command during a sweep is also a bench scenario.

// File: rtl/tmap_pkg.sv
package tmap_pkg;
  // Control-to-datapath strobes
  typedef struct packed {
    logic load;     // capture the command and zero the sweep counters
    logic advance;  // step to the next row / unit
  } tmapStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SWEEP = 2'd1,
    ST_FIN   = 2'd2
  } tmapState_t;
endpackage

// File: rtl/tmap_ctrl.sv
module tmap_ctrl
  import tmap_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic        sweepEnd,
  output tmapStrobe_t strobe,
  output logic        cmdReady,
  output logic        busy,
  output logic        done
);
  tmapState_t state, stateNext;

  always_comb begin
    strobe.load    = cmdValid && (state != ST_SWEEP);
    strobe.advance = (state == ST_SWEEP);
    stateNext      = state;
    case (state)
      ST_IDLE:  if (cmdValid) stateNext = ST_SWEEP;
      ST_SWEEP: if (sweepEnd) stateNext = ST_FIN;
      ST_FIN:   stateNext = cmdValid ? ST_SWEEP : ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign cmdReady = (state != ST_SWEEP);
  assign busy     = (state == ST_SWEEP);
  assign done     = (state == ST_FIN);
endmodule

// File: rtl/tmap_datapath.sv
module tmap_datapath
  import tmap_pkg::*;
#(
  parameter int W = 2,
  parameter int N = 3,
  parameter int K = 4,
  parameter int L = 2,
  localparam int C  = N * W,
  localparam int KW = $clog2(K),
  localparam int LW = $clog2(L),
  localparam int NW = (N > 1) ? $clog2(N) : 1,
  localparam int AW = KW + LW
) (
  input  logic          clk,
  input  logic          rstN,
  input  tmapStrobe_t   strobe,
  input  logic          cmdDelete,
  input  logic [AW-1:0] cmdAddr,
  input  logic [C-1:0]  cmdValue,
  input  logic [C-1:0]  cmdMask,
  output logic          sweepEnd,
  output logic [LW-1:0] wrLayer,
  output logic [NW-1:0] wrUnit,
  output logic [W-1:0]  wrRow,
  output logic [K-1:0]  wrColSel,
  output logic          wrBit
);
  logic          delReg;
  logic [AW-1:0] addrReg;
  logic [C-1:0]  valReg, maskReg;
  logic [NW-1:0] unitCnt;
  logic [W-1:0]  rowCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      delReg  <= 1'b0;
      addrReg <= '0;
      valReg  <= '0;
      maskReg <= '0;
      unitCnt <= '0;
      rowCnt  <= '0;
    end else if (strobe.load) begin
      delReg  <= cmdDelete;
      addrReg <= cmdAddr;
      valReg  <= cmdValue;
      maskReg <= cmdMask;
      unitCnt <= '0;
      rowCnt  <= '0;
    end else if (strobe.advance) begin
      rowCnt <= rowCnt + 1'b1;
      if (rowCnt == '1) unitCnt <= unitCnt + 1'b1;
    end
  end

  // Split the rule into per-unit subwords
  logic [W-1:0] subVal  [N];
  logic [W-1:0] subMask [N];
  for (genvar g = 0; g < N; g++) begin : g_split
    assign subVal[g]  = valReg[g*W +: W];
    assign subMask[g] = maskReg[g*W +: W];
  end

  logic [W-1:0] curVal, curMask;
  always_comb begin
    curVal  = '0;
    curMask = '0;
    for (int i = 0; i < N; i++) begin
      if (unitCnt == NW'(i)) begin
        curVal  = subVal[i];
        curMask = subMask[i];
      end
    end
  end

  // Column decode from the low address bits
  logic [KW-1:0] colIdx;
  assign colIdx = addrReg[KW-1:0];
  for (genvar c = 0; c < K; c++) begin : g_col
    assign wrColSel[c] = (colIdx == KW'(c));
  end

  assign wrLayer  = addrReg[AW-1:KW];
  assign wrUnit   = unitCnt;
  assign wrRow    = rowCnt;
  assign wrBit    = !delReg && (((rowCnt ^ curVal) & ~curMask) == '0);
  assign sweepEnd = (unitCnt == NW'(N-1)) && (rowCnt == '1);
endmodule

// File: rtl/ternary_rule_mapper.sv
module ternary_rule_mapper
  import tmap_pkg::*;
#(
  parameter int W = 2,
  parameter int N = 3,
  parameter int K = 4,
  parameter int L = 2,
  localparam int C  = N * W,
  localparam int KW = $clog2(K),
  localparam int LW = $clog2(L),
  localparam int NW = (N > 1) ? $clog2(N) : 1,
  localparam int AW = KW + LW
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdValid,
  output logic          cmdReady,
  input  logic          cmdDelete,
  input  logic [AW-1:0] cmdAddr,
  input  logic [C-1:0]  cmdValue,
  input  logic [C-1:0]  cmdMask,
  output logic          wrEn,
  output logic [LW-1:0] wrLayer,
  output logic [NW-1:0] wrUnit,
  output logic [W-1:0]  wrRow,
  output logic [K-1:0]  wrColSel,
  output logic          wrBit,
  output logic          busy,
  output logic          done
);
  tmapStrobe_t strobe;
  logic        sweepEnd;

  tmap_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .sweepEnd (sweepEnd),
    .strobe   (strobe),
    .cmdReady (cmdReady),
    .busy     (busy),
    .done     (done)
  );

  tmap_datapath #(.W(W), .N(N), .K(K), .L(L)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cmdDelete (cmdDelete),
    .cmdAddr   (cmdAddr),
    .cmdValue  (cmdValue),
    .cmdMask   (cmdMask),
    .sweepEnd  (sweepEnd),
    .wrLayer   (wrLayer),
    .wrUnit    (wrUnit),
    .wrRow     (wrRow),
    .wrColSel  (wrColSel),
    .wrBit     (wrBit)
  );

  assign wrEn = busy;
endmodule

// File: rtl/ternary_rule_mapper_checker.sv
module ternary_rule_mapper_checker #(
  parameter int W = 2,
  parameter int N = 3,
  parameter int K = 4,
  parameter int L = 2,
  localparam int LW = $clog2(L),
  localparam int NW = (N > 1) ? $clog2(N) : 1
) (
  input logic          clk,
  input logic          rstN,
  input logic          cmdValid,
  input logic          cmdReady,
  input logic          wrEn,
  input logic [LW-1:0] wrLayer,
  input logic [NW-1:0] wrUnit,
  input logic [W-1:0]  wrRow,
  input logic [K-1:0]  wrColSel,
  input logic          busy,
  input logic          done
);
  a_r3_sweep_start: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady) |=> (busy && wrRow == '0 && wrUnit == '0));

  a_r3_row_step: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrRow != '1) |=> (busy && wrRow == $past(wrRow) + 1'b1 && wrUnit == $past(wrUnit)));

  a_r3_unit_step: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrRow == '1 && wrUnit != NW'(N-1)) |=> (busy && wrRow == '0 && wrUnit == $past(wrUnit) + 1'b1));

  a_r3_sweep_stop: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrRow == '1 && wrUnit == NW'(N-1)) |=> !busy);

  a_r4_col_onehot: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> $onehot(wrColSel));

  a_r4_target_steady: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrRow != '1) |=> ($stable(wrColSel) && $stable(wrLayer)));

  a_r2_refuse_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !cmdReady);

  a_r8_done_after_sweep: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (done && cmdReady));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r9_we_tracks_busy: assert property (@(posedge clk) disable iff (!rstN)
    wrEn == busy);
endmodule

bind ternary_rule_mapper ternary_rule_mapper_checker #(.W(W), .N(N), .K(K), .L(L)) u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .cmdValid (cmdValid),
  .cmdReady (cmdReady),
  .wrEn     (wrEn),
  .wrLayer  (wrLayer),
  .wrUnit   (wrUnit),
  .wrRow    (wrRow),
  .wrColSel (wrColSel),
  .busy     (busy),
  .done     (done)
);

// File: tb/test_ternary_rule_mapper.sv
module test_ternary_rule_mapper;
  localparam int W = 2, N = 3, K = 4, L = 2;
  localparam int C = N * W, KW = $clog2(K), LW = $clog2(L);
  localparam int NW = (N > 1) ? $clog2(N) : 1;
  localparam int AW = KW + LW, ROWS = 1 << W;

  logic          clk = 1'b0, rstN = 1'b0;
  logic          cmdValid = 1'b0, cmdDelete = 1'b0;
  logic [AW-1:0] cmdAddr = '0;
  logic [C-1:0]  cmdValue = '0, cmdMask = '0;
  logic          cmdReady, wrEn, wrBit, busy, done;
  logic [LW-1:0] wrLayer;
  logic [NW-1:0] wrUnit;
  logic [W-1:0]  wrRow;
  logic [K-1:0]  wrColSel;

  int testsRun = 0, testsFailed = 0;
  logic finished = 1'b0;

  always #10 clk = ~clk;

  ternary_rule_mapper #(.W(W), .N(N), .K(K), .L(L)) i_ternary_rule_mapper (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdDelete(cmdDelete), .cmdAddr(cmdAddr), .cmdValue(cmdValue), .cmdMask(cmdMask),
    .wrEn(wrEn), .wrLayer(wrLayer), .wrUnit(wrUnit), .wrRow(wrRow),
    .wrColSel(wrColSel), .wrBit(wrBit), .busy(busy), .done(done)
  );

  // Bench copy of the SRAM units
  logic [K-1:0] mem [L][N][ROWS];
  logic memClr = 1'b0;
  always @(posedge clk) begin
    if (memClr) begin
      for (int l = 0; l < L; l++)
        for (int u = 0; u < N; u++)
          for (int r = 0; r < ROWS; r++) mem[l][u][r] <= '0;
    end else if (wrEn) begin
      for (int c = 0; c < K; c++)
        if (wrColSel[c]) mem[wrLayer][wrUnit][wrRow][c] <= wrBit;
    end
  end

  // Rules the table should hold
  logic          ruleValid [L*K];
  logic [C-1:0]  ruleVal   [L*K];
  logic [C-1:0]  ruleMask  [L*K];

  function automatic logic covers(input logic [C-1:0] v, input logic [C-1:0] m,
                                  input int u, input int row);
    for (int j = 0; j < W; j++)
      if (!m[u*W+j] && (((row >> j) & 1) != int'(v[u*W+j]))) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check(input bit ok, input string req, input string msg,
                       input longint act, input longint exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, msg, act, exp);
    end
  endtask

  task automatic testReset();
    rstN = 1'b0;
    memClr = 1'b1;
    for (int i = 0; i < L*K; i++) begin
      ruleValid[i] = 1'b0; ruleVal[i] = '0; ruleMask[i] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    memClr = 1'b0;
    @(negedge clk);
    check(!busy && !done && !wrEn && cmdReady, "R1", "reset outputs",
          {busy, done, wrEn, cmdReady}, 4'b0001);
  endtask

  // One command, checked cycle by cycle; optional intrusion during the sweep
  task automatic runRule(input int addr, input logic [C-1:0] v, input logic [C-1:0] m,
                         input bit del, input bit intrude);
    int layer = addr / K, col = addr % K;
    int ones;
    bit posOk, bitOk;
    @(negedge clk);
    check(cmdReady == 1'b1, "R2", "ready before command", cmdReady, 1);
    cmdValid = 1'b1; cmdDelete = del; cmdAddr = AW'(addr); cmdValue = v; cmdMask = m;
    @(negedge clk);
    cmdValid = 1'b0; cmdDelete = 1'b0;
    for (int u = 0; u < N; u++) begin
      ones = 0;
      for (int r = 0; r < ROWS; r++) begin
        posOk = wrEn && busy && int'(wrUnit) == u && int'(wrRow) == r;
        check(posOk, "R3", "sweep position", {wrEn, 6'(wrUnit), 8'(wrRow)},
              {1'b1, 6'(u), 8'(r)});
        check(int'(wrLayer) == layer && wrColSel == (K'(1) << col), "R4", "target column",
              {8'(wrLayer), 8'(wrColSel)}, {8'(layer), 8'(K'(1) << col)});
        bitOk = (wrBit == (!del && covers(v, m, u, r)));
        check(bitOk, del ? "R7" : "R5", "written bit", wrBit, !del && covers(v, m, u, r));
        if (wrBit) ones++;
        if (intrude && u == 0 && r == 1) begin
          cmdValid = 1'b1; cmdDelete = 1'b1; cmdAddr = AW'((addr + 1) % (L*K));
          cmdValue = ~v; cmdMask = '0;
        end
        if (intrude && u == 0 && (r == 1 || r == 2))
          check(cmdReady == 1'b0, "R2", "refused while busy", cmdReady, 0);
        if (intrude && u == 0 && r == 2) cmdValid = 1'b0;
        @(negedge clk);
      end
      if (!del)
        check(ones == (1 << $countones(m[u*W +: W])), "R6", "rows marked per unit",
              ones, 1 << $countones(m[u*W +: W]));
    end
    check(done && !busy && cmdReady && !wrEn, "R8", "done pulse", {done, busy, cmdReady, wrEn},
          4'b1010);
    ruleValid[addr] = !del; ruleVal[addr] = v; ruleMask[addr] = m;
    @(negedge clk);
    check(!done, "R8", "done single cycle", done, 0);
    if (intrude) begin
      for (int i = 0; i < 3; i++) begin
        check(!wrEn && !busy, "R2", "no sweep from refused command", {wrEn, busy}, 0);
        @(negedge clk);
      end
    end
  endtask

  task automatic tableCheck(input string req, input string msg);
    int bad = 0;
    logic expBit;
    logic actBit;
    for (int l = 0; l < L; l++)
      for (int u = 0; u < N; u++)
        for (int r = 0; r < ROWS; r++)
          for (int c = 0; c < K; c++) begin
            expBit = ruleValid[l*K+c] && covers(ruleVal[l*K+c], ruleMask[l*K+c], u, r);
            actBit = mem[l][u][r][c];
            if (actBit !== expBit) begin
              if (bad == 0)
                $display("FAIL %s %s: layer %0d unit %0d row %0d col %0d actual %0b expected %0b",
                         req, msg, l, u, r, c, actBit, expBit);
              bad++;
            end
          end
    testsRun++;
    if (bad != 0) testsFailed++;
  endtask

  task automatic testIdleQuiet();
    for (int i = 0; i < 4; i++) begin
      check(!wrEn && !busy && cmdReady, "R9", "idle no writes", {wrEn, busy, cmdReady}, 3'b001);
      @(negedge clk);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    testReset();
    testIdleQuiet();
    runRule(0, 6'b10_01_11, 6'b00_00_00, 1'b0, 1'b0);       // exact rule
    tableCheck("R5", "exact rule table");
    runRule(5, 6'b01_10_00, 6'b11_01_00, 1'b0, 1'b0);       // mixed don't-care
    tableCheck("R6", "mixed rule table");
    runRule(3, 6'b10_00_11, 6'b00_11_00, 1'b0, 1'b0);       // shares rows with entry 0
    tableCheck("R5", "shared rows table");
    runRule(0, 6'b00_11_01, 6'b00_00_10, 1'b0, 1'b0);       // overwrite entry 0
    tableCheck("R10", "overwrite table");
    runRule(5, 6'b00_00_00, 6'b00_00_00, 1'b1, 1'b0);       // delete entry 5
    tableCheck("R7", "delete table");
    runRule(7, 6'b11_11_11, 6'b11_11_11, 1'b0, 1'b1);       // all don't-care, intrusion
    tableCheck("R2", "refused command table");
    testIdleQuiet();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule